// File: doc/BRIEF.md
# Programmable Product-Term Sum Cell

This block is the purely combinational logic core of one cell in a programmable logic array. It receives a vector of input literals and a set of static configuration inputs. The configuration defines five product terms. Each term is the AND of any chosen literals, taken in true or complemented form. A per-term steering bit sends each term either into the cell's OR sum or out to a control output. A register stage in a neighbouring block can use that control output as a clock, clock enable, reset, preset or output enable.

The local OR sum is widened by a cascade input from an adjacent cell. The widened sum is driven out again as the cascade output, so that cells can be strung into long sum-of-products chains. Eight cells in a row give a 40-term sum. The widened sum then passes through an XOR whose second input is a constant 0, a constant 1 or one selected product term. This provides output polarity choice and XOR-style logic. A separate foldback output carries the inverse of one selected product term, for use on a regional bus.

All configuration is static. Programming of the configuration, the register stage, pin buffers and the global routing are handled elsewhere.

Top module: `pterm_cell`

## Requirements
- R1: Product term t (0..4) is the AND of every literal l for which `lit_true_i[t*N_LIT+l]` is 1, taken true, and every literal l for which `lit_comp_i[t*N_LIT+l]` is 1, taken complemented.
- R2: A product term with no enable bits set evaluates to 1. A term that enables both the true and the complemented form of the same literal evaluates to 0.
- R3: The local sum is the OR of the terms whose `sum_route_i` bit is 1. A term whose bit is 0 adds nothing to the sum.
- R4: `cas_o` equals the local sum ORed with `cas_i`.
- R5: `cell_o` equals `cas_o` XOR a second input chosen by `xor_mode_i`. The code 2'b00 selects constant 0 and 2'b01 selects constant 1, which inverts the output. Codes 2'b10 and 2'b11 select product term `xor_sel_i`.
- R6: `ctrl_o[t]` carries term t when `sum_route_i[t]` is 0, and is 0 when the term is routed to the sum.
- R7: `fold_o` is the inverse of product term `fold_sel_i`.
- R8: A selector value of 5 to 7 on `xor_sel_i` or `fold_sel_i` picks a term of value 0. The XOR input is then 0 and `fold_o` is then 1.
- R9: Feeding `cas_o` of one cell into `cas_i` of the next across eight cells yields the OR of all 40 routed terms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lits_i | input | N_LIT | Input literals |
| lit_true_i | input | 5*N_LIT | True-form literal enables, term t at bits t*N_LIT.. |
| lit_comp_i | input | 5*N_LIT | Complement-form literal enables, same packing |
| sum_route_i | input | 5 | 1 = term goes to the OR sum, 0 = term goes to control |
| xor_mode_i | input | 2 | XOR second-input choice |
| xor_sel_i | input | 3 | Term index for the XOR input |
| fold_sel_i | input | 3 | Term index for the foldback output |
| cas_i | input | 1 | Cascade sum from the neighbouring cell |
| ctrl_o | output | 5 | Terms available for control duties |
| cas_o | output | 1 | Widened sum before polarity |
| cell_o | output | 1 | Sum after the XOR |
| fold_o | output | 1 | Inverted selected term |

## Verification
One product term can serve several roles in the same evaluation. It can be routed into the OR sum and also selected as the XOR input and as the foldback source. In that case the term both sets and cancels the output. The bench provokes this with directed vectors that point `xor_sel_i` and `fold_sel_i` at a routed, true term, and with random configurations in which the selectors often coincide with routed terms. Each case is judged against a behavioural model that evaluates every role of the term independently.

// File: rtl/pterm_pkg.sv
package pterm_pkg;

    localparam int unsigned N_PT  = 5;
    localparam int unsigned SEL_W = $clog2(N_PT);

    typedef enum logic [1:0] {
        XM_ZERO = 2'b00,
        XM_ONE  = 2'b01,
        XM_TERM = 2'b10,
        XM_TALT = 2'b11
    } xor_mode_e;

    typedef struct packed {
        logic local_sum;
        logic chain_sum;
    } sum_bus_t;

    // Selected term, or 0 for an index past the last term.
    function automatic logic pick_term(input logic [N_PT-1:0] terms,
                                       input logic [SEL_W-1:0] sel);
        logic r;
        r = 1'b0;
        for (int i = 0; i < N_PT; i++) begin
            if (sel == SEL_W'(i)) r = terms[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/pterm_and.sv
module pterm_and
    import pterm_pkg::*;
#(
    parameter int unsigned N_LIT = 16
) (
    input  logic [N_LIT-1:0]      lits_i,
    input  logic [N_PT*N_LIT-1:0] en_true_i,
    input  logic [N_PT*N_LIT-1:0] en_comp_i,
    output logic [N_PT-1:0]       terms_o
);
    for (genvar t = 0; t < N_PT; t++) begin : g_term
        logic [N_LIT-1:0] tru;
        logic [N_LIT-1:0] cmp;
        assign tru = en_true_i[t*N_LIT +: N_LIT];
        assign cmp = en_comp_i[t*N_LIT +: N_LIT];
        // Every enabled literal must hold its required value.
        assign terms_o[t] = (&(~tru | lits_i)) & (&(~cmp | ~lits_i));
    end
endmodule

// File: rtl/pterm_sum.sv
module pterm_sum
    import pterm_pkg::*;
(
    input  logic [N_PT-1:0] terms_i,
    input  logic [N_PT-1:0] route_i,
    input  logic            cas_i,
    output logic [N_PT-1:0] ctrl_o,
    output sum_bus_t        sum_o
);
    always_comb begin
        sum_o.local_sum = |(terms_i & route_i);
        sum_o.chain_sum = sum_o.local_sum | cas_i;
        ctrl_o          = terms_i & ~route_i;
    end
endmodule

// File: rtl/pterm_out.sv
module pterm_out
    import pterm_pkg::*;
(
    input  logic [N_PT-1:0]  terms_i,
    input  sum_bus_t         sum_i,
    input  xor_mode_e        mode_i,
    input  logic [SEL_W-1:0] xor_sel_i,
    input  logic [SEL_W-1:0] fold_sel_i,
    output logic             cell_o,
    output logic             fold_o
);
    logic xin;

    always_comb begin
        unique case (mode_i)
            XM_ZERO:          xin = 1'b0;
            XM_ONE:           xin = 1'b1;
            XM_TERM, XM_TALT: xin = pick_term(terms_i, xor_sel_i);
            default:          xin = 1'b0;
        endcase
        cell_o = sum_i.chain_sum ^ xin;
        fold_o = ~pick_term(terms_i, fold_sel_i);
    end
endmodule

// File: rtl/pterm_cell.sv
module pterm_cell
    import pterm_pkg::*;
#(
    parameter int unsigned N_LIT = 16
) (
    input  logic [N_LIT-1:0]      lits_i,
    input  logic [N_PT*N_LIT-1:0] lit_true_i,
    input  logic [N_PT*N_LIT-1:0] lit_comp_i,
    input  logic [N_PT-1:0]       sum_route_i,
    input  logic [1:0]            xor_mode_i,
    input  logic [SEL_W-1:0]      xor_sel_i,
    input  logic [SEL_W-1:0]      fold_sel_i,
    input  logic                  cas_i,
    output logic [N_PT-1:0]       ctrl_o,
    output logic                  cas_o,
    output logic                  cell_o,
    output logic                  fold_o
);
    logic [N_PT-1:0] terms;
    sum_bus_t        sums;

    pterm_and #(.N_LIT(N_LIT)) u_and (
        .lits_i    (lits_i),
        .en_true_i (lit_true_i),
        .en_comp_i (lit_comp_i),
        .terms_o   (terms)
    );

    pterm_sum u_sum (
        .terms_i (terms),
        .route_i (sum_route_i),
        .cas_i   (cas_i),
        .ctrl_o  (ctrl_o),
        .sum_o   (sums)
    );

    pterm_out u_out (
        .terms_i    (terms),
        .sum_i      (sums),
        .mode_i     (xor_mode_e'(xor_mode_i)),
        .xor_sel_i  (xor_sel_i),
        .fold_sel_i (fold_sel_i),
        .cell_o     (cell_o),
        .fold_o     (fold_o)
    );

    assign cas_o = sums.chain_sum;
endmodule

// File: rtl/pterm_cell_chk.sv
module pterm_cell_chk
    import pterm_pkg::*;
(
    input logic [N_PT-1:0]  sum_route_i,
    input logic [1:0]       xor_mode_i,
    input logic [SEL_W-1:0] fold_sel_i,
    input logic             cas_i,
    input logic [N_PT-1:0]  ctrl_o,
    input logic             cas_o,
    input logic             cell_o,
    input logic             fold_o
);
    always_comb begin
        if (!$isunknown({sum_route_i, xor_mode_i, fold_sel_i, cas_i,
                         ctrl_o, cas_o, cell_o, fold_o})) begin
            // R4
            cas_pass_chk: assert (!cas_i || cas_o);
            // R3
            no_route_zero_chk: assert ((sum_route_i != '0) || (cas_o == cas_i));
            // R6
            ctrl_gate_chk: assert ((ctrl_o & sum_route_i) == '0);
            // R5
            pol_zero_chk: assert ((xor_mode_i != 2'b00) || (cell_o == cas_o));
            // R5
            pol_one_chk: assert ((xor_mode_i != 2'b01) || (cell_o == !cas_o));
            // R7
            fold_inv_chk: assert ((int'(fold_sel_i) >= N_PT) || sum_route_i[fold_sel_i]
                                  || (fold_o == !ctrl_o[fold_sel_i]));
            // R8
            fold_range_chk: assert ((int'(fold_sel_i) < N_PT) || fold_o);
        end
    end
endmodule

bind pterm_cell pterm_cell_chk u_chk (.*);

// File: tb/pterm_cell_tb.sv
module pterm_cell_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 16;
    localparam int NP = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NL-1:0]    lits;
    logic [NP*NL-1:0] ltru, lcmp;
    logic [NP-1:0]    route;
    logic [1:0]       xmode;
    logic [2:0]       xsel, fsel;
    logic             casi;
    logic [NP-1:0]    ctrl;
    logic             caso, cello, foldo;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    pterm_cell #(.N_LIT(NL)) u_dut (
        .lits_i(lits), .lit_true_i(ltru), .lit_comp_i(lcmp),
        .sum_route_i(route), .xor_mode_i(xmode), .xor_sel_i(xsel),
        .fold_sel_i(fsel), .cas_i(casi), .ctrl_o(ctrl), .cas_o(caso),
        .cell_o(cello), .fold_o(foldo)
    );

    // Behavioural reference
    bit [NP-1:0] m_term, m_ctrl;
    bit m_cas, m_cell, m_fold;

    task automatic model();
        int sum;
        bit xin, ft;
        m_term = '0;
        for (int t = 0; t < NP; t++) begin
            bit ok = 1;
            for (int l = 0; l < NL; l++) begin
                if (ltru[t*NL+l] && !lits[l]) ok = 0;
                if (lcmp[t*NL+l] && lits[l]) ok = 0;
            end
            m_term[t] = ok;
        end
        sum = 0;
        for (int t = 0; t < NP; t++) begin
            if (route[t] && m_term[t]) sum++;
            m_ctrl[t] = route[t] ? 1'b0 : m_term[t];
        end
        m_cas = (sum > 0) || casi;
        xin = (xsel < NP) ? m_term[xsel] : 1'b0;
        ft  = (fsel < NP) ? m_term[fsel] : 1'b0;
        if (xmode == 2'b00) m_cell = m_cas;
        else if (xmode == 2'b01) m_cell = !m_cas;
        else m_cell = m_cas != xin;
        m_fold = !ft;
    endtask

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    // Apply current inputs, wait to mid-cycle, compare all outputs.
    task automatic cmp_all(string tag);
        @(negedge clk);
        model();
        chk({tag, " R6 ctrl"}, 32'(ctrl), 32'(m_ctrl));
        chk({tag, " R3/R4 cas"}, 32'(caso), 32'(m_cas));
        chk({tag, " R5 cell"}, 32'(cello), 32'(m_cell));
        chk({tag, " R7 fold"}, 32'(foldo), 32'(m_fold));
    endtask

    task automatic clear_cfg();
        ltru = '0; lcmp = '0; route = '0; xmode = 2'b00;
        xsel = 3'd0; fsel = 3'd0; casi = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        lits = '0;
        clear_cfg();
        repeat (2) @(posedge clk);
        rst = 1'b0;

        // Reset-state: empty terms are 1 (R2), all go to control (R6)
        @(negedge clk);
        chk("R2 R6 idle ctrl", 32'(ctrl), 32'h1f);
        chk("R4 idle cas", 32'(caso), 0);
        chk("R5 idle cell", 32'(cello), 0);
        chk("R7 idle fold", 32'(foldo), 0);

        // R1: term0 = lit3 & ~lit5
        @(posedge clk);
        clear_cfg(); route = 5'b00001;
        ltru[3] = 1'b1; lcmp[5] = 1'b1;
        lits = 16'h0008;
        @(negedge clk); chk("R1 term true", 32'(caso), 1);
        @(posedge clk); lits = 16'h0028;
        @(negedge clk); chk("R1 term false", 32'(caso), 0);

        // R2: contradiction on term1
        @(posedge clk);
        clear_cfg(); route = 5'b00010;
        ltru[NL+7] = 1'b1; lcmp[NL+7] = 1'b1;
        lits = 16'hffff;
        @(negedge clk); chk("R2 contradiction", 32'(caso), 0);

        // R3: unrouted true term adds nothing; R6 sees it on ctrl
        @(posedge clk);
        clear_cfg(); route = 5'b00000;
        @(negedge clk);
        chk("R3 unrouted sum", 32'(caso), 0);
        chk("R6 unrouted ctrl", 32'(ctrl), 32'h1f);

        // R4: cascade alone
        @(posedge clk); casi = 1'b1;
        @(negedge clk); chk("R4 cascade in", 32'(caso), 1);

        // R5: invert polarity
        @(posedge clk); xmode = 2'b01;
        @(negedge clk); chk("R5 invert", 32'(cello), 0);

        // Shared-role cycle: term2 routed, also XOR input and foldback
        @(posedge clk);
        clear_cfg(); route = 5'b00100; xmode = 2'b10; xsel = 3'd2; fsel = 3'd2;
        @(negedge clk);
        chk("R5 routed xor cancel", 32'(cello), 0);
        chk("R7 fold of routed", 32'(foldo), 0);
        chk("R6 routed ctrl low", 32'(ctrl), 32'h1b);

        // R8: out-of-range selectors
        @(posedge clk); xsel = 3'd6; fsel = 3'd7;
        @(negedge clk);
        chk("R8 xor sel range", 32'(cello), 1);
        chk("R8 fold sel range", 32'(foldo), 1);

        // R9: eight chained cells, only a term in cell 5 true
        for (int pass = 0; pass < 2; pass++) begin
            logic c = 1'b0;
            for (int k = 0; k < 8; k++) begin
                @(posedge clk);
                clear_cfg(); route = 5'b11111; casi = c; lits = 16'h0001;
                for (int t = 0; t < NP; t++) lcmp[t*NL] = 1'b1;
                if (pass == 1 && k == 5) lcmp[3*NL] = 1'b0;
                @(negedge clk);
                c = caso;
            end
            chk("R9 40-term chain", 32'(c), 32'(pass));
        end

        // Random sweep against model
        for (int n = 0; n < 3000; n++) begin
            @(posedge clk);
            lits = 16'($urandom);
            for (int b = 0; b < NP*NL; b++) begin
                ltru[b] = ($urandom % 12) == 0;
                lcmp[b] = ($urandom % 12) == 0;
            end
            route = 5'($urandom); xmode = 2'($urandom);
            xsel = 3'($urandom); fsel = 3'($urandom); casi = ($urandom % 4) == 0;
            cmp_all("rand R1 R2");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule